// File: doc/BRIEF.md
# Write-Through Store Queue

This block sits between a write-through data cache and a slow main memory. Every store the processor issues is written to the cache and also placed in this queue as an address/data pair. The queue hands its oldest entry to the memory controller and keeps it there until the memory reports that the write cycle has finished. Only then does it move on to the next entry, so main memory sees stores in exactly the order the processor made them.

A memory write takes many clock cycles. A burst of stores can therefore arrive faster than memory absorbs them, and the queue fills no matter how deep it is. When that happens the block lowers its store-ready signal. The processor must then hold its store, and nothing is ever dropped. A full queue still takes a new store in the same cycle in which memory retires the oldest one.

Top module: `wt_store_queue`

## Requirements
- R1: While reset is high, and in the first cycle after reset is released, buf_empty is 1, buf_full is 0, mem_req is 0 and st_ready is 1.
- R2: mem_req is 1 in every cycle in which at least one entry is held, and 0 otherwise. A store accepted into an empty queue raises mem_req in the cycle right after the accepting clock edge.
- R3: Entries leave through the memory port in the same order in which they were accepted. Each mem_ack while mem_req is high retires exactly the entry shown on mem_addr/mem_data in that cycle.
- R4: While mem_req is high, mem_addr and mem_data show the oldest held entry. They stay unchanged until the cycle after mem_ack.
- R5: The number of held entries falls only at a clock edge where mem_ack and mem_req are both high. buf_full is 1 exactly when DEPTH (default 4) entries are held.
- R6: st_ready is 0 when DEPTH entries are held and mem_ack is low. A store presented while st_ready is 0 is not stored.
- R7: When the queue is full and mem_ack is high, st_ready is 1. A store presented in that cycle is accepted while the oldest entry is retired, and the queue stays full.
- R8: buf_empty is 1 exactly when no entry is held. It rises only in the cycle after the last held entry is acknowledged.
- R9: mem_ack while mem_req is low has no effect. The queue stays empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| st_valid | input | 1 | Processor presents a store |
| st_ready | output | 1 | Queue can take the store this cycle |
| st_addr | input | ADDR_W (32) | Store address |
| st_data | input | DATA_W (32) | Store data word |
| mem_req | output | 1 | An entry waits to be written to memory |
| mem_ack | input | 1 | Memory finished writing the presented entry (one-cycle pulse) |
| mem_addr | output | ADDR_W (32) | Address of the oldest entry |
| mem_data | output | DATA_W (32) | Data of the oldest entry |
| buf_full | output | 1 | All DEPTH entries are occupied |
| buf_empty | output | 1 | No entry is held |

## Verification
The two functions that can fall in the same cycle are the acceptance of a new store and the retirement of the head entry by a memory acknowledge. The hardest case is when this happens with the queue already full. To provoke it, the bench drives stores on every cycle against a memory model whose write latency is longer than the store interval, so the queue saturates and each acknowledge lands on a full queue with a store waiting. A reference queue in the bench predicts the occupancy, the ready level and the head entry in each such cycle. The bench counts these full-queue coincidences and requires at least one, then confirms through the drained order that the store taken in that cycle was neither lost nor duplicated.

// File: rtl/wsq_pkg.sv
package wsq_pkg;
  localparam int unsigned WSQ_ADDR_W = 32;
  localparam int unsigned WSQ_DATA_W = 32;
  localparam int unsigned WSQ_DEPTH  = 4;

  function automatic int unsigned wsq_ptr_w(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/wsq_ram.sv
module wsq_ram #(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = wsq_pkg::wsq_ptr_w(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  // small distributed memory: one write port, asynchronous read of the head slot
  logic [WIDTH-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slots[waddr] <= wdata;
  end

  assign rdata = slots[raddr];
endmodule

// File: rtl/wsq_ctrl.sv
module wsq_ctrl #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = wsq_pkg::wsq_ptr_w(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             full_q,
  output logic             empty_q
);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [CNT_W-1:0] occ_q;
  logic [CNT_W-1:0] occ_nxt;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    occ_nxt = occ_q;
    if (push && !pop) occ_nxt = occ_q + CNT_W'(1);
    if (pop && !push) occ_nxt = occ_q - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q   <= '0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      occ_q   <= occ_nxt;
      full_q  <= (occ_nxt == CNT_MAX);
      empty_q <= (occ_nxt == '0);
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
    end
  end
endmodule

// File: rtl/wt_store_queue.sv
module wt_store_queue #(
  parameter int unsigned ADDR_W = wsq_pkg::WSQ_ADDR_W,
  parameter int unsigned DATA_W = wsq_pkg::WSQ_DATA_W,
  parameter int unsigned DEPTH  = wsq_pkg::WSQ_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              mem_req,
  input  logic              mem_ack,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              buf_full,
  output logic              buf_empty
);
  localparam int unsigned PTR_W = wsq_pkg::wsq_ptr_w(DEPTH);
  localparam int unsigned ENT_W = ADDR_W + DATA_W;

  logic             push, pop;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             full_q, empty_q;
  logic [ENT_W-1:0] head;

  // retire only when something is presented; a full queue frees a slot in the same cycle
  assign pop      = mem_ack && !empty_q;
  assign st_ready = !full_q || pop;
  assign push     = st_valid && st_ready;

  wsq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .push    (push),
    .pop     (pop),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .full_q  (full_q),
    .empty_q (empty_q)
  );

  wsq_ram #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (push),
    .waddr (wr_ptr),
    .wdata ({st_addr, st_data}),
    .raddr (rd_ptr),
    .rdata (head)
  );

  assign mem_req   = !empty_q;
  assign mem_addr  = head[ENT_W-1:DATA_W];
  assign mem_data  = head[DATA_W-1:0];
  assign buf_full  = full_q;
  assign buf_empty = empty_q;
endmodule

// File: rtl/wsq_checker.sv
module wsq_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              st_valid,
  input logic              st_ready,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic              buf_full,
  input logic              buf_empty
);
  // R1: reset leaves the queue empty with no request
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (buf_empty && !buf_full && !mem_req));

  // R2 / R8: a request is raised exactly when something is held
  assert_req_matches_empty_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req == !buf_empty);

  // R4: the head is held steady until acknowledged
  assert_head_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));

  // R5: without an acknowledge the queue cannot become empty
  assert_no_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (!buf_empty && !mem_ack) |=> !buf_empty);

  // R6: a full queue stalls the processor unless memory retires an entry
  assert_full_stalls_R6: assert property (@(posedge clk) disable iff (rst)
    (buf_full && !mem_ack) |-> !st_ready);

  // R7: full plus acknowledge accepts a store and stays full
  assert_swap_when_full_R7: assert property (@(posedge clk) disable iff (rst)
    (buf_full && mem_ack && st_valid) |=> buf_full);

  // R9: an acknowledge with nothing requested leaves the queue empty
  assert_stray_ack_R9: assert property (@(posedge clk) disable iff (rst)
    (buf_empty && mem_ack && !st_valid) |=> buf_empty);

  // R6: never both full and empty
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    !(buf_full && buf_empty));
endmodule

bind wt_store_queue wsq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wsq_checker (
  .clk       (clk),
  .rst       (rst),
  .st_valid  (st_valid),
  .st_ready  (st_ready),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data),
  .buf_full  (buf_full),
  .buf_empty (buf_empty)
);

// File: tb/test_wt_store_queue.sv
`timescale 1ns/1ps
module test_wt_store_queue;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        st_valid, st_ready;
  logic [31:0] st_addr, st_data;
  logic        mem_req, mem_ack;
  logic [31:0] mem_addr, mem_data;
  logic        buf_full, buf_empty;

  int checks = 0;
  int errors = 0;
  int wcnt = 0;
  int swaps = 0;
  bit done = 0;
  logic [63:0] model_q[$];

  always #4 clk = ~clk;

  wt_store_queue i_wt_store_queue (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_data(mem_data), .buf_full(buf_full), .buf_empty(buf_empty)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: memory model picks ack, processor picks a store, then predict and compare
  task automatic step(input int pv, input int lat, input bit hold, input bit spur);
    int sz;
    bit pop_now, exp_rdy;
    logic [63:0] front;
    @(negedge clk);
    if (mem_req) begin
      if (!hold && wcnt >= lat) begin mem_ack = 1'b1; wcnt = 0; end
      else begin mem_ack = 1'b0; wcnt++; end
    end else begin
      wcnt = 0;
      mem_ack = spur && ($urandom_range(3) == 0);
    end
    st_valid = ($urandom_range(99) < pv);
    st_addr  = $urandom;
    st_data  = $urandom;
    #1;
    sz = model_q.size();
    front = (sz != 0) ? model_q[0] : 64'h0;
    check(buf_empty == (sz == 0), "R8 empty flag", 64'(buf_empty), 64'(sz == 0));
    check(buf_full == (sz == DEPTH), "R5 full flag", 64'(buf_full), 64'(sz == DEPTH));
    check(mem_req == (sz != 0), "R2 request", 64'(mem_req), 64'(sz != 0));
    if (sz != 0) check({mem_addr, mem_data} == front, "R4 head entry", {mem_addr, mem_data}, front);
    pop_now = mem_ack && (sz != 0);
    exp_rdy = (sz < DEPTH) || pop_now;
    check(st_ready == exp_rdy, "R6 ready", 64'(st_ready), 64'(exp_rdy));
    if (pop_now) begin
      front = model_q.pop_front();
      check({mem_addr, mem_data} == front, "R3 drain order", {mem_addr, mem_data}, front);
    end
    if (st_valid && st_ready) begin
      if (sz == DEPTH) swaps++;
      model_q.push_back({st_addr, st_data});
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; st_valid = 1'b0; mem_ack = 1'b0; st_addr = '0; st_data = '0;
    repeat (3) @(negedge clk);
    #1;
    check(buf_empty === 1'b1, "R1 empty in reset", 64'(buf_empty), 64'd1);
    check(buf_full === 1'b0, "R1 full in reset", 64'(buf_full), 64'd0);
    check(mem_req === 1'b0, "R1 req in reset", 64'(mem_req), 64'd0);
    check(st_ready === 1'b1, "R1 ready in reset", 64'(st_ready), 64'd1);
    @(negedge clk); rst = 1'b0;
    #1;
    check(buf_empty === 1'b1 && mem_req === 1'b0, "R1 after release", {buf_empty, mem_req}, 64'd2);

    // R9: stray acknowledges on an empty queue
    repeat (20) step(0, 2, 0, 1);
    check(buf_empty === 1'b1, "R9 stray ack keeps empty", 64'(buf_empty), 64'd1);

    // R2: single store then slow drain
    step(100, 3, 0, 0);
    repeat (10) step(0, 3, 0, 0);

    // R5/R6: fill with memory held off, stores keep coming and must be refused
    repeat (20) step(100, 0, 1, 0);
    check(buf_full === 1'b1, "R5 full while ack withheld", 64'(buf_full), 64'd1);
    repeat (30) step(0, 1, 0, 0);

    // R7: saturation, stores every cycle against a slow memory
    repeat (300) step(100, 5, 0, 0);
    check(swaps > 0, "R7 full push with pop seen", 64'(swaps), 64'd1);

    // mixed random traffic
    for (int i = 0; i < 3000; i++) step(int'($urandom_range(90)), int'($urandom_range(6)), 0, 1);

    // drain to empty
    for (int i = 0; i < 100 && model_q.size() != 0; i++) step(0, 2, 0, 0);
    step(0, 2, 0, 0);
    check(buf_empty === 1'b1 && mem_req === 1'b0, "R8 empty after last ack", {buf_empty, mem_req}, 64'd2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule